// File: doc/BRIEF.md
# CAN Error and Overload Frame Sequencer

This block runs at the CAN bit rate next to a protocol engine. It produces the node's own transmitted bit while an error frame, an overload frame or the interframe gap is on the bus. It also decides when the node may start a new transmission. The engine supplies one strobe per sampled bit, the sampled bus level, and three event strobes: error detected, frame finished, and overload wanted. It also supplies the current error-passive status. Error counting, CRC and bit stuffing stay in the engine. Dominant is 0 and recessive is 1. Whenever no flag is being sent, the block drives recessive.

The sequencer has eight named states:

- `ST_IDLE`: the bus is idle.
- `ST_FRAME`: a frame is in progress and is handled elsewhere.
- `ST_EFLAG`: the node sends its own error flag.
- `ST_OFLAG`: the node sends its own overload flag.
- `ST_ECHO`: the node waits for the first recessive bit after its flag.
- `ST_DELIM`: the eight-bit delimiter.
- `ST_IFS`: the three intermission bits.
- `ST_SUSP`: the six recessive bits that an error-passive node must see before it transmits again.

The transitions are:

- **IDLE→FRAME**: a dominant bit, which is a start of frame.
- **FRAME→IFS**: frame end.
- **IDLE/FRAME/DELIM/IFS/SUSP→EFLAG**: error detected.
- **EFLAG/OFLAG→ECHO**: after the sixth flag bit.
- **ECHO→DELIM**: the first recessive bit.
- **DELIM→IFS**: the eighth delimiter bit.
- **IFS→OFLAG**: a dominant bit in intermission bit 1 or 2, or an overload request in bit 1 while the bus is recessive. Either one is allowed only while fewer than two overload frames have run back to back.
- **IFS→FRAME**: a dominant bit in intermission bit 3, or any dominant bit once the overload cap is reached.
- **IFS→IDLE** or **IFS→SUSP**: after the third recessive intermission bit. The block goes to SUSP when the last error flag was sent while error-passive.
- **SUSP→IDLE**: after six recessive bits.
- **SUSP→FRAME**: a dominant bit.

Top module: `can_errovl_seq`

## Requirements
- R1: After reset, tx_bit=1, busy=0, tx_ready=1 and sof_in_ifs=0, with the sequencer in bus idle.
- R2: All outputs change only on a clock edge where bit_tick=1. Event inputs present on edges without bit_tick have no effect.
- R3: Error detection applies in idle, frame, delimiter, intermission or suspend, and only while error-active. After the tick that carries err_det, tx_bit is 0 for exactly six bit periods and then returns to 1. busy is 1 from that tick on.
- R4: An error flag started while error-passive keeps tx_bit at 1. With the bus recessive, busy stays high for exactly 14 bit ticks after the starting tick.
- R5: The eight-bit delimiter count starts at the first recessive bit sampled after the node's own six flag bits. Each extra dominant echo bit lengthens busy by one tick.
- R6: err_det arriving while the node's own flag is being sent does not restart or lengthen that flag.
- R7: The delimiter is followed by three intermission bits. With a recessive bus and no pending suspension, tx_ready becomes 1 on the third intermission tick and not before.
- R8: A dominant bit in the first or second intermission bit starts an overload frame: six dominant bits, then the echo wait and an eight-bit delimiter, then a new intermission.
- R9: A dominant bit in the third intermission bit starts no flag. It sets sof_in_ifs for exactly one bit period, keeps tx_bit=1 and busy=0, and moves the block to frame state with tx_ready=0.
- R10: ovl_req starts an overload frame only in the first intermission bit while the bus is recessive. Anywhere else it leaves tx_bit and busy unchanged.
- R11: At most two overload frames run back to back. A dominant bit in the intermission after the second is taken as a start of frame and raises sof_in_ifs. The count restarts once a frame has started.
- R12: After an error frame sent while error-passive, tx_ready stays 0 through the intermission and six further recessive bits. A dominant bit in that window starts a frame and cancels the pending suspension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled bus level for this bit (0 = dominant) |
| err_det | input | 1 | Error detected in this bit |
| err_passive | input | 1 | Node is error-passive |
| frame_end | input | 1 | This bit is the last bit of a frame's end field |
| ovl_req | input | 1 | Internal request to delay the next frame |
| tx_bit | output | 1 | Bit to drive onto the bus (0 = dominant) |
| busy | output | 1 | An error or overload frame is in progress |
| sof_in_ifs | output | 1 | A start of frame was seen in intermission |
| tx_ready | output | 1 | The bus is idle and the node may start a frame |

## Verification
The assertions assume that the engine raises event strobes only together with bit_tick. They also assume that frame_end is given only while a frame is running and that rx_bit is stable at each tick. The stimulus drives every input in the low phase of the clock and asserts strobes only inside a single-cycle bit tick. It spaces ticks several cycles apart, so the no-tick stability properties are exercised. The sweeps cover:

- echo lengths, injected repeat errors and the passive status;
- the intermission bit that carries a dominant level;
- the two-frame overload cap;
- suspension, with and without an interrupting frame.

// File: rtl/can_seq_pkg.sv
package can_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FRAME,
        ST_EFLAG,
        ST_OFLAG,
        ST_ECHO,
        ST_DELIM,
        ST_IFS,
        ST_SUSP
    } seq_state_t;

    function automatic logic is_err_ovl(input seq_state_t s);
        return (s == ST_EFLAG) || (s == ST_OFLAG) || (s == ST_ECHO) || (s == ST_DELIM);
    endfunction

endpackage

// File: rtl/seq_phase_cnt.sv
module seq_phase_cnt #(
    parameter int MAXV = 8,
    localparam int W   = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            if (restart) begin
                cnt <= '0;
            end else if (cnt != W'(MAXV)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/seq_ovl_limit.sv
module seq_ovl_limit #(
    parameter int MAX_OVL = 2,
    localparam int LW     = $clog2(MAX_OVL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    input  logic clear,
    output logic allow
);

    logic [LW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (clear) begin
            run_q <= '0;
        end else if (bump) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign allow = (run_q < LW'(MAX_OVL));

    // R11
    ovl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LW'(MAX_OVL));

    // R11
    ovl_bump_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bump |-> allow);

endmodule

// File: rtl/can_errovl_seq.sv
module can_errovl_seq
    import can_seq_pkg::*;
#(
    parameter int FLAG_BITS  = 6,
    parameter int DELIM_BITS = 8,
    parameter int IFS_BITS   = 3,
    parameter int SUSP_BITS  = 6,
    parameter int MAX_OVL    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic err_det,
    input  logic err_passive,
    input  logic frame_end,
    input  logic ovl_req,
    output logic tx_bit,
    output logic busy,
    output logic sof_in_ifs,
    output logic tx_ready
);

    localparam int MAXLEN = (DELIM_BITS > FLAG_BITS) ?
                            ((DELIM_BITS > SUSP_BITS) ? DELIM_BITS : SUSP_BITS) :
                            ((FLAG_BITS > SUSP_BITS) ? FLAG_BITS : SUSP_BITS);
    localparam int CW = $clog2(MAXLEN + 1);

    seq_state_t st, nxt;
    logic [CW-1:0] cnt;
    logic          ovl_allow;
    logic          pas_q;
    logic          susp_pend_q;
    logic          sof_now;
    logic          new_err;
    logic          new_ovl;
    logic          flag_pas;

    seq_phase_cnt #(.MAXV(MAXLEN)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .restart (nxt != st),
        .cnt     (cnt)
    );

    seq_ovl_limit #(.MAX_OVL(MAX_OVL)) u_ovl (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bit_tick && new_ovl),
        .clear (bit_tick && (nxt == ST_FRAME || nxt == ST_IDLE ||
                             nxt == ST_SUSP  || nxt == ST_EFLAG)),
        .allow (ovl_allow)
    );

    // next-state decision, applied only on a bit tick
    always_comb begin
        nxt     = st;
        sof_now = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (err_det)      nxt = ST_EFLAG;
                else if (!rx_bit) nxt = ST_FRAME;
            end
            ST_FRAME: begin
                if (err_det)        nxt = ST_EFLAG;
                else if (frame_end) nxt = ST_IFS;
            end
            ST_EFLAG, ST_OFLAG: begin
                if (cnt == CW'(FLAG_BITS - 1)) nxt = ST_ECHO;
            end
            ST_ECHO: begin
                if (rx_bit) nxt = ST_DELIM;
            end
            ST_DELIM: begin
                if (err_det)                          nxt = ST_EFLAG;
                else if (cnt == CW'(DELIM_BITS - 2))  nxt = ST_IFS;
            end
            ST_IFS: begin
                if (err_det) begin
                    nxt = ST_EFLAG;
                end else if (!rx_bit) begin
                    if (cnt < CW'(IFS_BITS - 1) && ovl_allow) begin
                        nxt = ST_OFLAG;
                    end else begin
                        nxt     = ST_FRAME;
                        sof_now = 1'b1;
                    end
                end else if (ovl_req && cnt == '0 && ovl_allow) begin
                    nxt = ST_OFLAG;
                end else if (cnt == CW'(IFS_BITS - 1)) begin
                    nxt = susp_pend_q ? ST_SUSP : ST_IDLE;
                end
            end
            ST_SUSP: begin
                if (err_det)                         nxt = ST_EFLAG;
                else if (!rx_bit)                    nxt = ST_FRAME;
                else if (cnt == CW'(SUSP_BITS - 1))  nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign new_err  = (nxt == ST_EFLAG) && (st != ST_EFLAG);
    assign new_ovl  = (nxt == ST_OFLAG) && (st != ST_OFLAG);
    assign flag_pas = new_err ? err_passive : pas_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            pas_q       <= 1'b0;
            susp_pend_q <= 1'b0;
        end else if (bit_tick) begin
            st <= nxt;
            if (new_err) begin
                pas_q <= err_passive;
            end
            if (new_err && err_passive) begin
                susp_pend_q <= 1'b1;
            end else if (nxt == ST_IDLE || nxt == ST_FRAME) begin
                susp_pend_q <= 1'b0;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit     <= 1'b1;
            busy       <= 1'b0;
            sof_in_ifs <= 1'b0;
            tx_ready   <= 1'b1;
        end else if (bit_tick) begin
            tx_bit     <= !((nxt == ST_EFLAG && !flag_pas) || nxt == ST_OFLAG);
            busy       <= is_err_ovl(nxt);
            sof_in_ifs <= sof_now;
            tx_ready   <= (nxt == ST_IDLE);
        end
    end

    // checker-side run length of driven dominant bits
    logic [CW:0] dom_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_run <= '0;
        end else if (bit_tick) begin
            if (tx_bit)                        dom_run <= '0;
            else if (dom_run != '1)            dom_run <= dom_run + 1'b1;
        end
    end

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> ($stable(tx_bit) && $stable(busy) && $stable(sof_in_ifs) && $stable(tx_ready)));

    // R3
    dom_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dom_run <= (CW+1)'(FLAG_BITS));

    // R3
    dom_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit |-> busy);

    // R6
    flag_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && st == ST_EFLAG && cnt != CW'(FLAG_BITS - 1)) |=> (cnt == $past(cnt) + 1'b1));

    // R7
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_bit && !busy));

    // R9
    sof_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_in_ifs |-> (tx_bit && !busy && !tx_ready));

endmodule

// File: tb/sim_can_errovl_seq.sv
module sim_can_errovl_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic rx_bit = 1'b1;
    logic err_det = 1'b0;
    logic err_passive = 1'b0;
    logic frame_end = 1'b0;
    logic ovl_req = 1'b0;
    logic tx_bit, busy, sof_in_ifs, tx_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_errovl_seq u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .err_det(err_det), .err_passive(err_passive), .frame_end(frame_end),
        .ovl_req(ovl_req), .tx_bit(tx_bit), .busy(busy),
        .sof_in_ifs(sof_in_ifs), .tx_ready(tx_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_bit(input logic rx, input logic e, input logic fe, input logic ov);
        @(negedge clk);
        rx_bit = rx; err_det = e; frame_end = fe; ovl_req = ov; bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; err_det = 1'b0; frame_end = 1'b0; ovl_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; rx_bit = 1'b1; err_passive = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic to_ifs();
        do_bit(1'b0, 1'b0, 1'b0, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        do_bit(1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    // rest of an overload/active flag after its start tick
    task automatic flag_body(output int dom, output int rec);
        dom = (tx_bit == 1'b0) ? 1 : 0;
        for (int f = 0; f < 6; f++) begin
            do_bit(1'b0, 1'b0, 1'b0, 1'b0);
            if (!tx_bit) dom++;
        end
        rec = 0;
        while (busy && rec < 40) begin
            do_bit(1'b1, 1'b0, 1'b0, 1'b0);
            rec++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int dom, rec, n;

        reset_dut();
        // R1 reset state
        chk("R1 tx_bit", tx_bit, 1);
        chk("R1 busy", busy, 0);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 sof_in_ifs", sof_in_ifs, 0);

        // R2 events without a tick are ignored
        @(negedge clk);
        rx_bit = 1'b0; err_det = 1'b1; ovl_req = 1'b1;
        repeat (3) @(negedge clk);
        err_det = 1'b0; ovl_req = 1'b0; rx_bit = 1'b1;
        @(negedge clk);
        chk("R2 tx_bit held", tx_bit, 1);
        chk("R2 busy held", busy, 0);
        chk("R2 tx_ready held", tx_ready, 1);

        // error sweep: passive x echo length x injected repeat error
        for (int pas = 0; pas < 2; pas++) begin
            for (int echo = 0; echo < 4; echo++) begin
                for (int inj = 0; inj < 6; inj++) begin
                    reset_dut();
                    err_passive = pas[0];
                    do_bit(1'b1, 1'b1, 1'b0, 1'b0);
                    chk("R3 busy on start", busy, 1);
                    dom = (tx_bit == 1'b0) ? 1 : 0;
                    n = 0;
                    for (int f = 1; f <= 6; f++) begin
                        do_bit(pas[0], (f == inj), 1'b0, 1'b0);
                        n++;
                        if (!tx_bit) dom++;
                    end
                    for (int k = 0; k < echo; k++) begin
                        do_bit(1'b0, 1'b0, 1'b0, 1'b0);
                        n++;
                        if (!tx_bit) dom++;
                    end
                    while (busy && n < 60) begin
                        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                        n++;
                    end
                    if (pas != 0)
                        chk("R4 passive flag stays recessive", dom, 0);
                    else if (inj != 0)
                        chk("R6 repeat error keeps six dominant", dom, 6);
                    else
                        chk("R3 six dominant bits", dom, 6);
                    if (echo == 0 && pas != 0)
                        chk("R4 fourteen-bit passive frame", n, 14);
                    else
                        chk("R5 frame length with echo", n, 14 + echo);
                    do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                    do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                    chk("R7 not ready inside intermission", tx_ready, 0);
                    do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                    if (pas == 0) begin
                        chk("R7 ready after intermission", tx_ready, 1);
                    end else begin
                        chk("R12 suspended after intermission", tx_ready, 0);
                        for (int s = 1; s <= 6; s++) begin
                            do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                            chk("R12 suspend window", tx_ready, (s == 6) ? 1 : 0);
                        end
                    end
                end
            end
        end

        // dominant bit position in intermission
        for (int p = 0; p < 3; p++) begin
            reset_dut();
            to_ifs();
            for (int i = 0; i < p; i++) do_bit(1'b1, 1'b0, 1'b0, 1'b0);
            do_bit(1'b0, 1'b0, 1'b0, 1'b0);
            if (p < 2) begin
                chk("R8 overload starts", tx_bit, 0);
                chk("R8 no sof flag", sof_in_ifs, 0);
                flag_body(dom, rec);
                chk("R8 overload dominant count", dom, 6);
                chk("R8 overload delimiter", rec, 8);
                do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                chk("R8 ready after new intermission", tx_ready, 1);
            end else begin
                chk("R9 sof flag", sof_in_ifs, 1);
                chk("R9 tx recessive", tx_bit, 1);
                chk("R9 not busy", busy, 0);
                chk("R9 not ready", tx_ready, 0);
                do_bit(1'b0, 1'b0, 1'b0, 1'b0);
                chk("R9 sof one bit only", sof_in_ifs, 0);
                do_bit(1'b1, 1'b0, 1'b1, 1'b0);
                do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                do_bit(1'b1, 1'b0, 1'b0, 1'b0);
                chk("R9 frame then idle", tx_ready, 1);
            end
        end

        // overload cap
        reset_dut();
        to_ifs();
        for (int o = 0; o < 2; o++) begin
            do_bit(1'b0, 1'b0, 1'b0, 1'b0);
            chk("R11 overload allowed", tx_bit, 0);
            flag_body(dom, rec);
            chk("R11 overload dominant count", dom, 6);
        end
        do_bit(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 third overload refused", tx_bit, 1);
        chk("R11 taken as sof", sof_in_ifs, 1);
        chk("R11 not busy", busy, 0);
        do_bit(1'b1, 1'b0, 1'b1, 1'b0);
        do_bit(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 count restarted after frame", tx_bit, 0);

        // overload request
        reset_dut();
        do_bit(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R10 request ignored in idle", tx_bit, 1);
        chk("R10 request ignored in idle busy", busy, 0);
        do_bit(1'b0, 1'b0, 1'b0, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R10 request ignored in frame", tx_bit, 1);
        do_bit(1'b1, 1'b0, 1'b1, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R10 request ignored at second bit", tx_bit, 1);
        chk("R10 request ignored at second bit busy", busy, 0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R10 ready after untouched intermission", tx_ready, 1);
        to_ifs();
        do_bit(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R10 request honoured at first bit", tx_bit, 0);
        chk("R10 busy", busy, 1);
        flag_body(dom, rec);
        chk("R10 overload dominant count", dom, 6);
        chk("R10 overload delimiter", rec, 8);

        // error detected during intermission
        reset_dut();
        to_ifs();
        do_bit(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 error in intermission", tx_bit, 0);
        chk("R3 error in intermission busy", busy, 1);

        // suspension interrupted by a frame
        reset_dut();
        err_passive = 1'b1;
        do_bit(1'b1, 1'b1, 1'b0, 1'b0);
        n = 0;
        while (busy && n < 40) begin
            do_bit(1'b1, 1'b0, 1'b0, 1'b0);
            n++;
        end
        chk("R4 passive frame length", n, 14);
        for (int i = 0; i < 5; i++) do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 still suspended", tx_ready, 0);
        do_bit(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R12 dominant starts frame", tx_ready, 0);
        chk("R12 no sof flag in suspend", sof_in_ifs, 0);
        chk("R12 not busy", busy, 0);
        err_passive = 1'b0;
        do_bit(1'b1, 1'b0, 1'b1, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        do_bit(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R12 suspension cancelled", tx_ready, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule